// File: doc/BRIEF.md
# Key-Locked Watchdog Timer with Early-Warning Interrupt

This block is a watchdog timer placed on a simple 32-bit register bus. A down-counter as wide as two 16-bit halves steps once for each pulse of a slow tick enable, nominally 32768 pulses per second, while its run bit is set. As the count falls, it first passes a programmable early-warning threshold. At that point a sticky flag sets and can raise an interrupt. When the count reaches zero, a second sticky flag sets and can raise a reset request. Software keeps the system alive by loading a fresh start value before the count runs out.

Every register write is dropped unless the lock register currently holds the unlock key. Both the start value and the threshold are written as two 16-bit halves. They do not reach the counter at once: they are committed on the second tick pulse after the last half is written. A busy status bit stays high during that wait, so software can poll it before it writes again. The register bus has no back-pressure. A write takes effect at the clock edge where `bus_en` and `bus_we` are both high. Read data depends only on `bus_addr` and is valid in the same cycle.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, every register reads zero, the lock is engaged (lock register bit 0 reads 0), the count is zero, and `irq_o` and `rst_req_o` are low.
- R2: A write of 0x0000E551 to the lock register (0x04) unlocks it, and a write of any other value locks it again. While it is locked, writes to every other register, the flag-clear register included, change nothing.
- R3: The load-low (0x08), load-high (0x0C), threshold-low (0x10) and threshold-high (0x14) registers each keep only write bits [15:0] and read them back zero-extended. The control register (0x00) keeps bits [2:0] and the mask register (0x20) keeps bit 0.
- R4: Status bit 2 (busy, status at 0x18) is high from the cycle after any accepted write to a load or threshold half until the second tick pulse after the last such write. On that pulse, the counter takes {load-high, load-low} and the threshold {threshold-high, threshold-low} takes effect.
- R5: While control bit 1 (run) is set, each tick pulse lowers the count by one. The count stays at zero once it gets there.
- R6: While run is clear, the count holds its value whatever the tick does.
- R7: Status bit 0 sets when a tick step brings the count onto the threshold. `irq_o` is that flag ANDed with control bit 0 and with the inverse of mask bit 0.
- R8: Status bit 1 sets when a tick step brings the count to zero. `rst_req_o` is that flag ANDed with control bit 2.
- R9: A write to the clear register (0x1C) with bit 0 set clears status bit 0, and one with bit 1 set clears status bit 1. Zero bits leave their flag unchanged.
- R10: A committed load while the counter is running restarts the count from the load value. This is the keep-alive.
- R11: The count reads back as bits [15:0] at 0x24 and bits [31:16] at 0x28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle slow tick enable |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | Reset request on expiry |

## Verification
The bench writes with the lock both open and closed. A design that lets a locked write through, or that ignores a relock, ends up with a control, mask or flag value different from the one predicted. It counts tick pulses across the commit wait. A commit made one pulse early or one pulse late, or a busy bit that clears at the wrong moment, shows up as a wrong count or a wrong status read. It also crosses the threshold, reaches zero and then keeps ticking, toggles the mask and the enables, and clears the flags one bit at a time. A wrong flag trigger, a leaking mask, a counter that wraps below zero, or a clear that hits the wrong flag each produces an output level that does not match.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int unsigned AW    = 6;
  localparam int unsigned BUS_W = 32;

  localparam logic [AW-1:0] A_CTRL = 6'h00;
  localparam logic [AW-1:0] A_LOCK = 6'h04;
  localparam logic [AW-1:0] A_LDLO = 6'h08;
  localparam logic [AW-1:0] A_LDHI = 6'h0C;
  localparam logic [AW-1:0] A_PRLO = 6'h10;
  localparam logic [AW-1:0] A_PRHI = 6'h14;
  localparam logic [AW-1:0] A_STAT = 6'h18;
  localparam logic [AW-1:0] A_CLR  = 6'h1C;
  localparam logic [AW-1:0] A_MASK = 6'h20;
  localparam logic [AW-1:0] A_CNLO = 6'h24;
  localparam logic [AW-1:0] A_CNHI = 6'h28;

  localparam int unsigned N_HALF = 4;

  typedef struct packed {
    logic rst_en;
    logic run;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  parameter logic [15:0] KEY    = 16'hE551,
  localparam int unsigned CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              pre_flag_i,
  input  logic              exp_flag_i,
  input  logic              busy_i,
  output ctrl_t             ctrl_o,
  output logic              mask_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [CNT_W-1:0]  pre_val_o,
  output logic              load_wr_o,
  output logic              clr_pre_o,
  output logic              clr_exp_o
);
  logic  unlocked_q;
  ctrl_t ctrl_q;
  logic  mask_q;
  logic  wr_any;
  logic  wr_ok;

  assign wr_any = bus_en && bus_we;
  assign wr_ok  = wr_any && unlocked_q;

  // lock register: written regardless of current lock state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
    end else if (wr_any && bus_addr == A_LOCK) begin
      unlocked_q <= (bus_wdata == BUS_W'(KEY));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= 1'b0;
    end else if (wr_ok) begin
      if (bus_addr == A_CTRL) ctrl_q <= ctrl_t'(bus_wdata[2:0]);
      if (bus_addr == A_MASK) mask_q <= bus_wdata[0];
    end
  end

  // four half-registers at consecutive word offsets from A_LDLO
  for (genvar g = 0; g < N_HALF; g++) begin : g_half
    localparam logic [AW-1:0] MY_A = A_LDLO + AW'(4 * g);
    logic [HALF_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_ok && bus_addr == MY_A) begin
        q <= bus_wdata[HALF_W-1:0];
      end
    end
  end

  assign load_val_o = {g_half[1].q, g_half[0].q};
  assign pre_val_o  = {g_half[3].q, g_half[2].q};
  assign load_wr_o  = wr_ok && (bus_addr == A_LDLO || bus_addr == A_LDHI ||
                                bus_addr == A_PRLO || bus_addr == A_PRHI);
  assign clr_pre_o  = wr_ok && bus_addr == A_CLR && bus_wdata[0];
  assign clr_exp_o  = wr_ok && bus_addr == A_CLR && bus_wdata[1];
  assign ctrl_o     = ctrl_q;
  assign mask_o     = mask_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata = {29'd0, ctrl_q};
      A_LOCK: bus_rdata = {31'd0, unlocked_q};
      A_LDLO: bus_rdata = BUS_W'(g_half[0].q);
      A_LDHI: bus_rdata = BUS_W'(g_half[1].q);
      A_PRLO: bus_rdata = BUS_W'(g_half[2].q);
      A_PRHI: bus_rdata = BUS_W'(g_half[3].q);
      A_STAT: bus_rdata = {29'd0, busy_i, exp_flag_i, pre_flag_i};
      A_MASK: bus_rdata = {31'd0, mask_q};
      A_CNLO: bus_rdata = BUS_W'(cnt_i[HALF_W-1:0]);
      A_CNHI: bus_rdata = BUS_W'(cnt_i[CNT_W-1:HALF_W]);
      default: bus_rdata = '0;
    endcase
  end

  AST_LOCKED_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !unlocked_q && bus_addr != A_LOCK) |=> $stable(ctrl_q)); // R2
  AST_LOCKED_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !unlocked_q && bus_addr != A_LOCK) |=> $stable(mask_q)); // R2
endmodule

// File: rtl/kwd_commit.sv
module kwd_commit #(
  parameter int unsigned COMMIT_TICKS = 2,
  localparam int unsigned SW = $clog2(COMMIT_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic load_wr_i,
  output logic busy_o,
  output logic commit_o
);
  logic [SW-1:0] left_q;

  assign busy_o   = (left_q != '0);
  assign commit_o = tick_i && (left_q == SW'(1)) && !load_wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (load_wr_i) begin
      left_q <= SW'(COMMIT_TICKS);
    end else if (tick_i && busy_o) begin
      left_q <= left_q - SW'(1);
    end
  end

  AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr_i |=> busy_o); // R4
  AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !busy_o); // R4
endmodule

// File: rtl/kwd_count.sv
module kwd_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             commit_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] pre_val_i,
  input  logic             clr_pre_i,
  input  logic             clr_exp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pre_flag_o,
  output logic             exp_flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thr_q;
  logic [CNT_W-1:0] cnt_dec;
  logic             step;
  logic             pre_q;
  logic             exp_q;

  assign cnt_dec = cnt_q - CNT_W'(1);
  assign step    = tick_i && run_i && !commit_i && (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      thr_q <= '0;
    end else if (commit_i) begin
      cnt_q <= load_val_i;
      thr_q <= pre_val_i;
    end else if (step) begin
      cnt_q <= cnt_dec;
    end
  end

  // a new event wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      if (step && cnt_dec == thr_q) pre_q <= 1'b1;
      else if (clr_pre_i)           pre_q <= 1'b0;
      if (step && cnt_dec == '0)    exp_q <= 1'b1;
      else if (clr_exp_i)           exp_q <= 1'b0;
    end
  end

  assign cnt_o      = cnt_q;
  assign pre_flag_o = pre_q;
  assign exp_flag_o = exp_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && run_i && !commit_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R5
  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !commit_i) |=> cnt_q == '0); // R5
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !commit_i) |=> $stable(cnt_q)); // R6
  AST_PRE_ON_THR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pre_q) |-> cnt_q == thr_q); // R7
  AST_EXP_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exp_q) |-> cnt_q == '0); // R8
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int unsigned HALF_W       = 16,
  parameter int unsigned COMMIT_TICKS = 2,
  parameter logic [15:0] KEY          = 16'hE551
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [5:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq_o,
  output logic             rst_req_o
);
  localparam int unsigned CNT_W = 2 * HALF_W;

  ctrl_t            ctrl;
  logic             mask;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] pre_val;
  logic             load_wr;
  logic             clr_pre;
  logic             clr_exp;
  logic             busy;
  logic             commit;
  logic [CNT_W-1:0] cnt;
  logic             pre_flag;
  logic             exp_flag;

  kwd_regs #(.HALF_W(HALF_W), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_i(cnt), .pre_flag_i(pre_flag), .exp_flag_i(exp_flag), .busy_i(busy),
    .ctrl_o(ctrl), .mask_o(mask), .load_val_o(load_val), .pre_val_o(pre_val),
    .load_wr_o(load_wr), .clr_pre_o(clr_pre), .clr_exp_o(clr_exp)
  );

  kwd_commit #(.COMMIT_TICKS(COMMIT_TICKS)) u_commit (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_wr_i(load_wr),
    .busy_o(busy), .commit_o(commit)
  );

  kwd_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(ctrl.run),
    .commit_i(commit), .load_val_i(load_val), .pre_val_i(pre_val),
    .clr_pre_i(clr_pre), .clr_exp_i(clr_exp),
    .cnt_o(cnt), .pre_flag_o(pre_flag), .exp_flag_o(exp_flag)
  );

  assign irq_o     = pre_flag && ctrl.irq_en && !mask;
  assign rst_req_o = exp_flag && ctrl.rst_en;

  AST_COMMIT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> cnt == $past(load_val)); // R10
endmodule

// File: tb/test_keyed_watchdog.sv
`timescale 1ns/1ps
module test_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        rst_req_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  keyed_watchdog i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  localparam logic [5:0] CTRL = 6'h00, LOCK = 6'h04, LDLO = 6'h08, LDHI = 6'h0C;
  localparam logic [5:0] PRLO = 6'h10, PRHI = 6'h14, STAT = 6'h18, CLR = 6'h1C;
  localparam logic [5:0] MASK = 6'h20, CNLO = 6'h24, CNHI = 6'h28;
  localparam logic [31:0] KEYV = 32'h0000E551;

  localparam int NV = 8;
  localparam logic [5:0]  V_ADDR [NV] = '{CTRL, CTRL, LDLO, LDHI, PRLO, MASK, MASK, CTRL};
  localparam logic [31:0] V_DATA [NV] = '{32'h5, 32'h2, 32'hABCD1234, 32'hFFFF5678,
                                          32'h9999, 32'h1, 32'h0, 32'h0};
  localparam logic        V_OPEN [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [31:0] V_EXP  [NV] = '{32'h5, 32'h5, 32'h1234, 32'h5678,
                                          32'h0, 32'h1, 32'h1, 32'h0};

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rchk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    do_reset();
    // table: lock state, write, readback
    for (int i = 0; i < NV; i++) begin
      wr(LOCK, V_OPEN[i] ? KEYV : 32'h0);
      wr(V_ADDR[i], V_DATA[i]);
      rchk(V_OPEN[i] ? "R3 table" : "R2 table", V_ADDR[i], V_EXP[i]);
    end

    do_reset();
    // R1 reset state
    rchk("R1 ctrl", CTRL, 0);
    rchk("R1 lock", LOCK, 0);
    rchk("R1 status", STAT, 0);
    rchk("R1 load", LDLO, 0);
    rchk("R1 count", CNLO, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 rst", {31'd0, rst_req_o}, 0);

    // R4 commit wait
    wr(LOCK, KEYV);
    rchk("R2 unlocked", LOCK, 1);
    wr(LDLO, 20); wr(LDHI, 0); wr(PRLO, 5); wr(PRHI, 0);
    rchk("R4 busy set", STAT, 32'h4);
    ticks(1);
    rchk("R4 still busy", STAT, 32'h4);
    rchk("R4 not yet loaded", CNLO, 0);
    ticks(1);
    rchk("R4 busy clear", STAT, 0);
    rchk("R4 loaded", CNLO, 20);

    // R5 counting
    wr(CTRL, 32'h7);
    ticks(5);
    rchk("R5 count 15", CNLO, 15);
    rchk("R11 count high", CNHI, 0);

    // R6 freeze
    wr(CTRL, 32'h5);
    ticks(3);
    rchk("R6 frozen", CNLO, 15);
    wr(CTRL, 32'h7);

    // R7 threshold
    ticks(9);
    rchk("R7 not at threshold", STAT, 0);
    chk("R7 irq low", {31'd0, irq_o}, 0);
    ticks(1);
    rchk("R7 flag", STAT, 32'h1);
    chk("R7 irq high", {31'd0, irq_o}, 1);
    wr(MASK, 1);
    chk("R7 masked", {31'd0, irq_o}, 0);
    wr(MASK, 0);
    chk("R7 unmasked", {31'd0, irq_o}, 1);
    wr(CTRL, 32'h6);
    chk("R7 irq disabled", {31'd0, irq_o}, 0);
    wr(CTRL, 32'h7);

    // R2 locked clear ignored, R9 bitwise clear
    wr(LOCK, 32'h0);
    wr(CLR, 32'h3);
    rchk("R2 locked clear", STAT, 32'h1);
    wr(CTRL, 32'h0);
    rchk("R2 locked ctrl", CTRL, 32'h7);
    wr(LOCK, 32'h0000E552);
    wr(CTRL, 32'h0);
    rchk("R2 wrong key", CTRL, 32'h7);
    wr(LOCK, KEYV);
    wr(CLR, 32'h2);
    rchk("R9 other bit", STAT, 32'h1);
    wr(CLR, 32'h1);
    rchk("R9 pre cleared", STAT, 0);
    chk("R9 irq cleared", {31'd0, irq_o}, 0);

    // R10 keep-alive
    wr(LDLO, 20);
    ticks(2);
    rchk("R10 reloaded", CNLO, 20);
    rchk("R10 not busy", STAT, 0);

    // R8 expiry
    ticks(19);
    rchk("R8 count 1", CNLO, 1);
    chk("R8 rst low", {31'd0, rst_req_o}, 0);
    ticks(1);
    rchk("R8 expired", STAT, 32'h3);
    chk("R8 rst high", {31'd0, rst_req_o}, 1);
    ticks(3);
    rchk("R5 hold zero", CNLO, 0);
    rchk("R5 hold zero high", CNHI, 0);
    wr(CTRL, 32'h3);
    chk("R8 rst disabled", {31'd0, rst_req_o}, 0);
    wr(CLR, 32'h2);
    rchk("R9 exp cleared", STAT, 32'h1);

    // R11 / R3 upper half
    wr(CTRL, 32'h0);
    wr(LDHI, 32'hAAAA0001); wr(LDLO, 32'h55550002);
    ticks(2);
    rchk("R11 high half", CNHI, 1);
    rchk("R11 low half", CNLO, 2);
    rchk("R3 half stored", LDHI, 1);

    report();
    $finish;
  end
endmodule